// File: doc/BRIEF.md
# Multi-PHY Receive Cell Port

This block is the PHY side of a shared receive cell bus. Several PHY devices sit on one bus, and an ATM layer master reads from them. The line side writes received cells into an internal cell store, one 16-bit word per cycle. The master reads them out over a 16-bit data bus. Each cell is 54 bytes long, so it moves as exactly 27 words, W0 to W26.

The master sends a 5-bit device address on every cycle. When that address matches the block's programmed address, the block answers the poll one cycle later with a cell-available flag. The block becomes the read target when its own address is on the bus at a clock edge where the active-low read enable is high. After that, every edge where the enable is low returns the next word of the cell, and a start-of-cell flag marks W0. The master may keep polling other addresses while it reads.

Address 1Fh is the null address and never gets an answer. The bus outputs come out as data plus drive enables, so the tri-state buffers sit at the pads. Three single-cycle events report problems:
- a read when no cell is waiting (underrun);
- a cell that arrives while the store is full (overrun);
- a runt cell cut short by the next start (alignment change).

Top module: `rx_cell_port`

## Requirements
- R1: `rd_clav_oe` is 1 only in the cycle after an edge where `rd_addr` equals `my_addr`. Address 5'h1F never produces a poll answer, even when `my_addr` is 5'h1F.
- R2: When `rd_clav_oe` is 1, `rd_clav` is 1 exactly when at least one complete cell is stored and its reading has not started. A cell whose reading has begun does not count.
- R3: The block becomes selected (`rd_data_oe`=1 after the edge) at an edge with `rd_enb_n`=1 and `rd_addr`=`my_addr` (not 5'h1F). It is deselected at an edge with `rd_enb_n`=1 and any other address except 5'h1F. Address 5'h1F with `rd_enb_n`=1 leaves the selection unchanged. Edges with `rd_enb_n`=0 never change the selection.
- R4: `rd_data_oe` is 0 whenever the block is not selected. `rd_data` and `rd_soc` are valid only while `rd_data_oe` is 1.
- R5: While selected, each edge with `rd_enb_n`=0 puts the next cell word on `rd_data` after that edge. Words come out in write order, 27 per cell. `rd_soc` is 1 exactly with W0. A cell left part-read on deselection continues from the next word when the block is selected again.
- R6: Address changes while `rd_enb_n`=0, including polls of other devices, do not skip, repeat or reorder cell words.
- R7: A read edge (selected, `rd_enb_n`=0) with no complete cell stored pulses `evt_underrun` for one cycle. No word is delivered and `rd_soc` is 0.
- R8: A word with `wr_sop`=1 that arrives while the store holds CELLS cells pulses `evt_overrun` for one cycle. The whole cell that starts with that word is discarded.
- R9: A `wr_sop` word that arrives after 1 to 26 words of an unfinished cell pulses `evt_align` for one cycle. The partial cell is dropped, and the new word starts a fresh cell.
- R10: Words written with `wr_sop`=0 while no cell is open are ignored.
- R11: After reset the block is deselected, both drive enables and all events are 0, and the store is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| my_addr | input | 5 | Programmed device address |
| wr_valid | input | 1 | Line-side word valid |
| wr_sop | input | 1 | Line-side word is W0 of a cell |
| wr_data | input | 16 | Line-side word |
| rd_addr | input | 5 | Device address from the master |
| rd_enb_n | input | 1 | Active-low read enable from the master |
| rd_data | output | 16 | Cell word to the master |
| rd_data_oe | output | 1 | Drive enable for rd_data and rd_soc |
| rd_soc | output | 1 | Start of cell, high with W0 |
| rd_clav | output | 1 | Cell-available poll answer |
| rd_clav_oe | output | 1 | Drive enable for rd_clav |
| evt_underrun | output | 1 | Read with no cell stored |
| evt_overrun | output | 1 | Cell dropped because the store was full |
| evt_align | output | 1 | Runt cell dropped |

## Verification
The assertions assume that `my_addr` is stable across any pair of adjacent cycles in which a poll or selection is judged. They also assume that line-side words arrive no faster than one per clock. The bench changes `my_addr` only while the bus is idle and the block is deselected, and it restores the address before the next transfer. Line writes use `wr_valid` in single-word steps, and reads are interleaved with polls only while the read enable is low, so selection changes are never mixed into a burst.

// File: rtl/rx_cell_pkg.sv
`timescale 1ns/1ps
package rx_cell_pkg;
  localparam int WORD_W     = 16;
  localparam int CELL_WORDS = 27;
  localparam int ADDR_W     = 5;
  localparam logic [ADDR_W-1:0] NULL_ADDR = 5'h1F;
endpackage

// File: rtl/rx_cell_assembler.sv
`timescale 1ns/1ps
module rx_cell_assembler #(
  parameter int WORDS  = rx_cell_pkg::CELL_WORDS,
  parameter int WORD_W = rx_cell_pkg::WORD_W,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic              wr_sop,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              store_full,
  output logic              st_we,
  output logic [IDX_W-1:0]  st_idx,
  output logic [WORD_W-1:0] st_data,
  output logic              st_commit,
  output logic              evt_overrun,
  output logic              evt_align
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WORDS - 1);

  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic             drop_q, drop_d;
  logic             ovr_q, ovr_d, aln_q, aln_d;

  always_comb begin
    cnt_d     = cnt_q;
    drop_d    = drop_q;
    ovr_d     = 1'b0;
    aln_d     = 1'b0;
    st_we     = 1'b0;
    st_commit = 1'b0;
    if (wr_valid) begin
      if (wr_sop) begin
        aln_d  = (cnt_q != '0);
        drop_d = store_full;
        ovr_d  = store_full;
        st_we  = !store_full;
        cnt_d  = IDX_W'(1);
      end else if (cnt_q != '0) begin
        st_we = !drop_q;
        if (cnt_q == LAST) begin
          st_commit = !drop_q;
          cnt_d     = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  assign st_idx  = wr_sop ? '0 : cnt_q;
  assign st_data = wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      drop_q <= 1'b0;
      ovr_q  <= 1'b0;
      aln_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      drop_q <= drop_d;
      ovr_q  <= ovr_d;
      aln_q  <= aln_d;
    end
  end

  assign evt_overrun = ovr_q;
  assign evt_align   = aln_q;

  p_align_after_sop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_align |-> $past(wr_valid && wr_sop));
  p_overrun_when_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_overrun |-> $past(store_full && wr_valid && wr_sop));
  p_commit_not_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    st_commit |-> !store_full);
endmodule

// File: rtl/rx_cell_store.sv
`timescale 1ns/1ps
module rx_cell_store #(
  parameter int CELLS  = 4,
  parameter int WORDS  = rx_cell_pkg::CELL_WORDS,
  parameter int WORD_W = rx_cell_pkg::WORD_W,
  localparam int IDX_W  = $clog2(WORDS),
  localparam int SLOT_W = (CELLS > 1) ? $clog2(CELLS) : 1,
  localparam int CNT_W  = $clog2(CELLS + 1),
  localparam int DEPTH  = CELLS * WORDS,
  localparam int MEM_AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              wr_commit,
  input  logic              rd_take,
  output logic [WORD_W-1:0] rd_word,
  output logic              rd_first,
  output logic              rd_has,
  output logic              cell_ready,
  output logic              full
);
  localparam logic [IDX_W-1:0]  LAST  = IDX_W'(WORDS - 1);
  localparam logic [SLOT_W-1:0] STOP  = SLOT_W'(CELLS - 1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [SLOT_W-1:0] wslot_q, wslot_d, rslot_q, rslot_d;
  logic [IDX_W-1:0]  ridx_q, ridx_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              pop;
  logic [MEM_AW-1:0] waddr, raddr;

  assign waddr = MEM_AW'(int'(wslot_q) * WORDS + int'(wr_idx));
  assign raddr = MEM_AW'(int'(rslot_q) * WORDS + int'(ridx_q));

  always_ff @(posedge clk) begin
    if (wr_en) mem[waddr] <= wr_data;
  end

  always_comb begin
    pop     = rd_take && (ridx_q == LAST);
    ridx_d  = ridx_q;
    rslot_d = rslot_q;
    wslot_d = wslot_q;
    if (rd_take) ridx_d = pop ? '0 : ridx_q + 1'b1;
    if (pop) rslot_d = (rslot_q == STOP) ? '0 : rslot_q + 1'b1;
    if (wr_commit) wslot_d = (wslot_q == STOP) ? '0 : wslot_q + 1'b1;
    cnt_d = cnt_q + CNT_W'(wr_commit) - CNT_W'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wslot_q <= '0;
      rslot_q <= '0;
      ridx_q  <= '0;
      cnt_q   <= '0;
    end else begin
      wslot_q <= wslot_d;
      rslot_q <= rslot_d;
      ridx_q  <= ridx_d;
      cnt_q   <= cnt_d;
    end
  end

  assign rd_word    = mem[raddr];
  assign rd_first   = (ridx_q == '0);
  assign rd_has     = (cnt_q != '0);
  assign full       = (cnt_q == CNT_W'(CELLS));
  assign cell_ready = (ridx_q == '0) ? (cnt_q != '0) : (cnt_q > CNT_W'(1));

  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(CELLS));
  p_mid_cell_has_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ridx_q != '0) |-> (cnt_q != '0));
endmodule

// File: rtl/rx_bus_ctrl.sv
`timescale 1ns/1ps
module rx_bus_ctrl #(
  parameter int ADDR_W = rx_cell_pkg::ADDR_W,
  parameter int WORD_W = rx_cell_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] my_addr,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_enb_n,
  input  logic              rd_has,
  input  logic              cell_ready,
  input  logic [WORD_W-1:0] rd_word,
  input  logic              rd_first,
  output logic              rd_take,
  output logic [WORD_W-1:0] data_q,
  output logic              soc_q,
  output logic              sel_q,
  output logic              clav_q,
  output logic              clav_oe_q,
  output logic              underrun_q
);
  localparam logic [ADDR_W-1:0] NULL_A = ADDR_W'(rx_cell_pkg::NULL_ADDR);

  logic              hit;
  logic              sel_d, soc_d, clav_d, clav_oe_d, underrun_d;
  logic [WORD_W-1:0] data_d;

  always_comb begin
    hit   = (rd_addr == my_addr) && (rd_addr != NULL_A);
    sel_d = sel_q;
    if (rd_enb_n) begin
      if (hit) sel_d = 1'b1;
      else if (rd_addr != NULL_A) sel_d = 1'b0;
    end
    rd_take    = sel_q && !rd_enb_n && rd_has;
    underrun_d = sel_q && !rd_enb_n && !rd_has;
    data_d     = rd_take ? rd_word : data_q;
    soc_d      = rd_take && rd_first;
    clav_oe_d  = hit;
    clav_d     = hit && cell_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q      <= 1'b0;
      data_q     <= '0;
      soc_q      <= 1'b0;
      clav_q     <= 1'b0;
      clav_oe_q  <= 1'b0;
      underrun_q <= 1'b0;
    end else begin
      sel_q      <= sel_d;
      data_q     <= data_d;
      soc_q      <= soc_d;
      clav_q     <= clav_d;
      clav_oe_q  <= clav_oe_d;
      underrun_q <= underrun_d;
    end
  end

  p_clav_own_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clav_oe_q |-> ($past(rd_addr) == $past(my_addr)) && ($past(rd_addr) != NULL_A));
  p_select_handshake_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_q) |-> $past(rd_enb_n) && ($past(rd_addr) == $past(my_addr)));
  p_enb_low_keeps_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_enb_n |=> $stable(sel_q));
  p_soc_only_selected_r5: assert property (@(posedge clk) disable iff (!rst_n)
    soc_q |-> sel_q);
  p_idle_holds_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_enb_n |=> $stable(data_q) && !soc_q);
  p_underrun_no_soc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_q |-> !soc_q);
endmodule

// File: rtl/rx_cell_port.sv
`timescale 1ns/1ps
module rx_cell_port #(
  parameter int CELLS  = 4,
  parameter int WORDS  = rx_cell_pkg::CELL_WORDS,
  parameter int WORD_W = rx_cell_pkg::WORD_W,
  parameter int ADDR_W = rx_cell_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] my_addr,
  input  logic              wr_valid,
  input  logic              wr_sop,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_enb_n,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_data_oe,
  output logic              rd_soc,
  output logic              rd_clav,
  output logic              rd_clav_oe,
  output logic              evt_underrun,
  output logic              evt_overrun,
  output logic              evt_align
);
  localparam int IDX_W = $clog2(WORDS);

  logic              st_we, st_commit, st_full;
  logic [IDX_W-1:0]  st_idx;
  logic [WORD_W-1:0] st_data, st_word;
  logic              st_first, st_has, st_ready, take;

  rx_cell_assembler #(.WORDS(WORDS), .WORD_W(WORD_W)) u_asm (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_sop(wr_sop), .wr_data(wr_data),
    .store_full(st_full),
    .st_we(st_we), .st_idx(st_idx), .st_data(st_data), .st_commit(st_commit),
    .evt_overrun(evt_overrun), .evt_align(evt_align)
  );

  rx_cell_store #(.CELLS(CELLS), .WORDS(WORDS), .WORD_W(WORD_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(st_we), .wr_idx(st_idx), .wr_data(st_data), .wr_commit(st_commit),
    .rd_take(take), .rd_word(st_word), .rd_first(st_first),
    .rd_has(st_has), .cell_ready(st_ready), .full(st_full)
  );

  rx_bus_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .my_addr(my_addr), .rd_addr(rd_addr), .rd_enb_n(rd_enb_n),
    .rd_has(st_has), .cell_ready(st_ready), .rd_word(st_word), .rd_first(st_first),
    .rd_take(take), .data_q(rd_data), .soc_q(rd_soc), .sel_q(rd_data_oe),
    .clav_q(rd_clav), .clav_oe_q(rd_clav_oe), .underrun_q(evt_underrun)
  );

  p_events_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_soc |-> rd_data_oe && !evt_underrun);
endmodule

// File: tb/rx_cell_port_tb.sv
`timescale 1ns/1ps
module rx_cell_port_tb;
  logic        clk, rst_n;
  logic [4:0]  my_addr, rd_addr;
  logic        wr_valid, wr_sop, rd_enb_n;
  logic [15:0] wr_data, rd_data;
  logic        rd_data_oe, rd_soc, rd_clav, rd_clav_oe;
  logic        evt_underrun, evt_overrun, evt_align;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic cap_ovr, cap_aln;

  rx_cell_port u_dut (
    .clk(clk), .rst_n(rst_n), .my_addr(my_addr),
    .wr_valid(wr_valid), .wr_sop(wr_sop), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_enb_n(rd_enb_n),
    .rd_data(rd_data), .rd_data_oe(rd_data_oe), .rd_soc(rd_soc),
    .rd_clav(rd_clav), .rd_clav_oe(rd_clav_oe),
    .evt_underrun(evt_underrun), .evt_overrun(evt_overrun), .evt_align(evt_align)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // poll table: addr, enb_n, exp clav_oe, exp clav, exp data_oe (one cell stored)
  typedef struct packed {
    logic [4:0] addr;
    logic       enb_n;
    logic       clav_oe;
    logic       clav;
    logic       data_oe;
  } vec_t;
  localparam vec_t VECS [8] = '{
    '{5'h03, 1'b0, 1'b1, 1'b1, 1'b0},
    '{5'h01, 1'b0, 1'b0, 1'b0, 1'b0},
    '{5'h1F, 1'b1, 1'b0, 1'b0, 1'b0},
    '{5'h03, 1'b1, 1'b1, 1'b1, 1'b1},
    '{5'h1F, 1'b1, 1'b0, 1'b0, 1'b1},
    '{5'h05, 1'b1, 1'b0, 1'b0, 1'b0},
    '{5'h1E, 1'b0, 1'b0, 1'b0, 1'b0},
    '{5'h03, 1'b0, 1'b1, 1'b1, 1'b0}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write_words(input int id, input int n);
    for (int i = 0; i < n; i++) begin
      wr_valid = 1'b1;
      wr_sop   = (i == 0);
      wr_data  = {8'(id), 8'(i)};
      tick();
      if (i == 0) begin
        cap_ovr = evt_overrun;
        cap_aln = evt_align;
      end
    end
    wr_valid = 1'b0;
    wr_sop   = 1'b0;
  endtask

  task automatic read_cell(input int id, input bit poll);
    rd_addr  = 5'h03;
    rd_enb_n = 1'b1;
    tick();
    chk(rd_data_oe == 1'b1, "R3 select", rd_data_oe, 1);
    rd_enb_n = 1'b0;
    for (int i = 0; i < 27; i++) begin
      if (poll) rd_addr = (i % 3 == 0) ? 5'h01 : ((i % 3 == 1) ? 5'h1F : 5'h03);
      tick();
      chk(rd_data == {8'(id), 8'(i)}, poll ? "R6 word under polling" : "R5 word order",
          rd_data, {8'(id), 8'(i)});
      chk(rd_soc == (i == 0), "R5 soc on W0", rd_soc, (i == 0));
    end
    rd_enb_n = 1'b1;
    rd_addr  = 5'h01;
    tick();
    chk(rd_data_oe == 1'b0, "R4 deselect drops drive", rd_data_oe, 0);
  endtask

  task automatic poll_clav(input logic exp, input string tag);
    rd_addr  = 5'h03;
    rd_enb_n = 1'b0;
    tick();
    chk(rd_clav_oe == 1'b1 && rd_clav == exp, tag, {rd_clav_oe, rd_clav}, {1'b1, exp});
    rd_addr = 5'h01;
    tick();
  endtask

  initial begin
    #(5ns * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; my_addr = 5'h03; rd_addr = 5'h01; rd_enb_n = 1'b1;
    wr_valid = 1'b0; wr_sop = 1'b0; wr_data = '0;
    cap_ovr = 1'b0; cap_aln = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R11 reset state
    chk(!rd_data_oe && !rd_clav_oe, "R11 enables low", {rd_data_oe, rd_clav_oe}, 0);
    chk(!evt_underrun && !evt_overrun && !evt_align, "R11 events low",
        {evt_underrun, evt_overrun, evt_align}, 0);
    poll_clav(1'b0, "R11 store empty");

    // table walk with one cell stored: R1 R2 R3
    write_words(1, 27);
    for (int k = 0; k < 8; k++) begin
      rd_addr  = VECS[k].addr;
      rd_enb_n = VECS[k].enb_n;
      tick();
      chk(rd_clav_oe == VECS[k].clav_oe, "R1 poll enable", rd_clav_oe, VECS[k].clav_oe);
      if (VECS[k].clav_oe) chk(rd_clav == VECS[k].clav, "R2 clav level", rd_clav, VECS[k].clav);
      chk(rd_data_oe == VECS[k].data_oe, "R3 selection", rd_data_oe, VECS[k].data_oe);
    end
    rd_addr = 5'h01; rd_enb_n = 1'b1;
    tick();

    // null address with my_addr = 1F: R1 R3
    my_addr = 5'h1F; rd_addr = 5'h1F; rd_enb_n = 1'b1;
    tick();
    tick();
    chk(!rd_clav_oe, "R1 null never polled", rd_clav_oe, 0);
    chk(!rd_data_oe, "R3 null never selected", rd_data_oe, 0);
    my_addr = 5'h03; rd_addr = 5'h01;
    tick();

    read_cell(1, 1'b0);
    poll_clav(1'b0, "R2 empty after read");

    // polling during read: R6
    write_words(2, 27);
    write_words(3, 27);
    read_cell(2, 1'b1);

    // partial read, clav excludes the cell in progress, resume: R2 R5
    rd_addr = 5'h03; rd_enb_n = 1'b1;
    tick();
    rd_enb_n = 1'b0;
    tick();
    chk(rd_data == {8'd3, 8'd0} && rd_soc, "R5 first word", rd_data, {8'd3, 8'd0});
    tick();
    chk(rd_clav_oe && !rd_clav, "R2 cell in progress not counted", rd_clav, 0);
    chk(rd_data == {8'd3, 8'd1}, "R5 second word", rd_data, {8'd3, 8'd1});
    rd_enb_n = 1'b1; rd_addr = 5'h01;
    tick();
    rd_addr = 5'h03;
    tick();
    rd_enb_n = 1'b0;
    for (int i = 2; i < 27; i++) begin
      tick();
      chk(rd_data == {8'd3, 8'(i)} && !rd_soc, "R5 resumed word", rd_data, {8'd3, 8'(i)});
    end
    rd_enb_n = 1'b1; rd_addr = 5'h01;
    tick();

    // stray words without sop ignored: R10; then underrun: R7
    for (int i = 0; i < 5; i++) begin
      wr_valid = 1'b1; wr_sop = 1'b0; wr_data = 16'hBEEF;
      tick();
    end
    wr_valid = 1'b0;
    poll_clav(1'b0, "R10 stray words ignored");
    rd_addr = 5'h03; rd_enb_n = 1'b1;
    tick();
    rd_enb_n = 1'b0;
    tick();
    chk(evt_underrun && !rd_soc, "R7 underrun pulse", evt_underrun, 1);
    rd_enb_n = 1'b1; rd_addr = 5'h01;
    tick();
    chk(!evt_underrun, "R7 underrun one cycle", evt_underrun, 0);

    // overrun: R8
    for (int c = 10; c < 14; c++) write_words(c, 27);
    chk(!cap_ovr, "R8 fourth cell accepted", cap_ovr, 0);
    write_words(14, 27);
    chk(cap_ovr, "R8 overrun pulse", cap_ovr, 1);
    chk(!evt_overrun, "R8 overrun one cycle", evt_overrun, 0);
    for (int c = 10; c < 14; c++) read_cell(c, 1'b0);
    poll_clav(1'b0, "R8 dropped cell absent");

    // runt: R9
    write_words(20, 10);
    write_words(21, 27);
    chk(cap_aln, "R9 align pulse", cap_aln, 1);
    read_cell(21, 1'b0);
    poll_clav(1'b0, "R9 runt dropped");

    // reset with content: R11
    write_words(30, 27);
    rst_n = 1'b0;
    tick();
    rst_n = 1'b1;
    tick();
    poll_clav(1'b0, "R11 reset empties store");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule